// File: doc/BRIEF.md
# Bayer Defective Pixel Rank Clamp

This block corrects isolated bad pixels in a raw Bayer stream one sample at a time. Each cycle it can accept a fully assembled 5x5 window of raw samples centred on the pixel being processed. With the window it receives the 2x2 colour filter phase, the row and column parity of the centre, a 2-bit sensitivity and a bypass control. It works out whether the centre is a green site or a red/blue site and picks the eight nearest samples of the same colour. It sorts them by intensity through a pipelined sorting network. The centre is then clamped into a band taken from the sorted list.

Sensitivity 0 allows the full minimum-to-maximum range of the neighbours. Each higher level pulls both band edges one rank toward the median. Two flags report whether the output was raised or lowered. There is no stored defect list: every decision depends only on the current window. Line buffers and register access belong to the surrounding pipeline.

Top module: `bayer_dpc_clamp`

## Requirements
- R1: A window position with row parity r and column parity c has colour class {r^cfa_phase[1], c^cfa_phase[0]}: 00 is red, 11 is blue, 01 and 10 are green. The centre is therefore green exactly when row_odd^col_odd^cfa_phase[1]^cfa_phase[0] is 1.
- R2: For a red or blue centre, the neighbour set is the four window corners (rows/cols 0 and 4) plus the four samples two steps away on the centre row and column. Window element (row i, col j) occupies in_win bits [(i*5+j)*DW +: DW], and the centre is (2,2).
- R3: For a green centre, the neighbour set is the four diagonal samples at (1,1), (1,3), (3,1) and (3,3), plus the same four axial samples at distance two.
- R4: With the neighbours sorted ascending as s[0..7] and sensitivity k in 0..3, the lower bound is s[k] and the upper bound is s[7-k]. At k=0 these are the neighbour minimum and maximum.
- R5: A centre below the lower bound is output as the lower bound, and flag_lo is raised.
- R6: A centre above the upper bound is output as the upper bound, and flag_hi is raised.
- R7: A centre within the bounds (inclusive) is output unchanged, and neither flag is raised.
- R8: When bypass is high, the centre is output unchanged with both flags low, whatever the neighbours are.
- R9: A sample accepted with in_valid at a clock edge appears with out_valid exactly 8 edges later. Back-to-back samples are accepted every cycle, and gaps in in_valid are reproduced at the output.
- R10: While rst_n is low, and until the first accepted sample has passed through, out_valid, flag_hi and flag_lo are low. Samples presented during reset never emerge.
- R11: flag_hi and flag_lo are never high together, and neither is high without out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Window on in_win is valid this cycle |
| in_win | input | 25*DW | 5x5 raw window, element (i,j) at bits (i*5+j)*DW |
| cfa_phase | input | 2 | Colour filter phase |
| row_odd | input | 1 | Row parity of the centre sample |
| col_odd | input | 1 | Column parity of the centre sample |
| sens | input | 2 | Sensitivity level 0 (weakest) to 3 |
| bypass | input | 1 | Pass the centre through untouched |
| out_valid | output | 1 | Output sample valid |
| out_pix | output | DW | Corrected sample |
| flag_hi | output | 1 | Sample was lowered from a high outlier |
| flag_lo | output | 1 | Sample was raised from a low outlier |

## Verification
A wrong comparator or layer order in the sorting network yields a wrong rank. This shows up as an off-by-one bound value on the next output that hits a clamp, eight cycles after the window entered. A misaligned side-band stage pairs a centre, sensitivity or bypass with the neighbours of a different window. Under back-to-back random traffic this produces wrong values or flags within a few samples. A wrong class decision pulls bounds from the other colour plane. The directed windows are built so that the two planes give clearly different clamp values.

// File: rtl/bayer_dpc_clamp.sv
module bayer_dpc_clamp #(
  parameter int DW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [25*DW-1:0] in_win,
  input  logic [1:0]       cfa_phase,
  input  logic             row_odd,
  input  logic             col_odd,
  input  logic [1:0]       sens,
  input  logic             bypass,
  output logic             out_valid,
  output logic [DW-1:0]    out_pix,
  output logic             flag_hi,
  output logic             flag_lo
);

  localparam int NN     = 8;
  localparam int LAYERS = 6;
  localparam int LAT    = LAYERS + 2;

  function automatic logic [DW-1:0] tap(input logic [25*DW-1:0] w, input int r, input int c);
    return w[(r*5+c)*DW +: DW];
  endfunction

  function automatic logic [NN*DW-1:0] net_layer(input logic [NN*DW-1:0] v, input int l);
    logic [DW-1:0] a [NN];
    logic [DW-1:0] t;
    logic [5:0]    pr [4];
    int            n;
    logic [NN*DW-1:0] r;
    for (int i = 0; i < NN; i++) a[i] = v[i*DW +: DW];
    for (int p = 0; p < 4; p++) pr[p] = '0;
    n = 0;
    case (l)
      0: begin pr[0] = {3'd0,3'd1}; pr[1] = {3'd2,3'd3}; pr[2] = {3'd4,3'd5}; pr[3] = {3'd6,3'd7}; n = 4; end
      1: begin pr[0] = {3'd0,3'd2}; pr[1] = {3'd1,3'd3}; pr[2] = {3'd4,3'd6}; pr[3] = {3'd5,3'd7}; n = 4; end
      2: begin pr[0] = {3'd1,3'd2}; pr[1] = {3'd5,3'd6}; n = 2; end
      3: begin pr[0] = {3'd0,3'd4}; pr[1] = {3'd1,3'd5}; pr[2] = {3'd2,3'd6}; pr[3] = {3'd3,3'd7}; n = 4; end
      4: begin pr[0] = {3'd2,3'd4}; pr[1] = {3'd3,3'd5}; n = 2; end
      default: begin pr[0] = {3'd1,3'd2}; pr[1] = {3'd3,3'd4}; pr[2] = {3'd5,3'd6}; n = 3; end
    endcase
    for (int p = 0; p < 4; p++) begin
      if (p < n && a[pr[p][5:3]] > a[pr[p][2:0]]) begin
        t = a[pr[p][5:3]];
        a[pr[p][5:3]] = a[pr[p][2:0]];
        a[pr[p][2:0]] = t;
      end
    end
    for (int i = 0; i < NN; i++) r[i*DW +: DW] = a[i];
    return r;
  endfunction

  wire green = row_odd ^ col_odd ^ cfa_phase[1] ^ cfa_phase[0];
  wire unused_taps = ^in_win;

  logic [NN*DW-1:0] pick;
  always_comb begin
    if (green)
      pick = {tap(in_win,1,1), tap(in_win,1,3), tap(in_win,3,1), tap(in_win,3,3),
              tap(in_win,0,2), tap(in_win,2,0), tap(in_win,2,4), tap(in_win,4,2)};
    else
      pick = {tap(in_win,0,0), tap(in_win,0,4), tap(in_win,4,0), tap(in_win,4,4),
              tap(in_win,0,2), tap(in_win,2,0), tap(in_win,2,4), tap(in_win,4,2)};
  end

  logic [NN*DW-1:0] stg [LAYERS+1];
  logic [DW-1:0]    ctr [LAYERS+1];
  logic [1:0]       sn  [LAYERS+1];
  logic             byp [LAYERS+1];
  logic             vld [LAYERS+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l <= LAYERS; l++) vld[l] <= 1'b0;
    end else begin
      vld[0] <= in_valid;
      for (int l = 0; l < LAYERS; l++) vld[l+1] <= vld[l];
    end
  end

  always_ff @(posedge clk) begin
    stg[0] <= pick;
    ctr[0] <= tap(in_win, 2, 2);
    sn[0]  <= sens;
    byp[0] <= bypass;
    for (int l = 0; l < LAYERS; l++) begin
      stg[l+1] <= net_layer(stg[l], l);
      ctr[l+1] <= ctr[l];
      sn[l+1]  <= sn[l];
      byp[l+1] <= byp[l];
    end
  end

  wire [2:0]    lo_i  = {1'b0, sn[LAYERS]};
  wire [2:0]    hi_i  = 3'd7 - lo_i;
  wire [DW-1:0] lo_b  = stg[LAYERS][lo_i*DW +: DW];
  wire [DW-1:0] hi_b  = stg[LAYERS][hi_i*DW +: DW];
  wire [DW-1:0] c_fin = ctr[LAYERS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      flag_hi   <= 1'b0;
      flag_lo   <= 1'b0;
    end else begin
      out_valid <= vld[LAYERS];
      out_pix   <= c_fin;
      flag_hi   <= 1'b0;
      flag_lo   <= 1'b0;
      if (!byp[LAYERS]) begin
        if (c_fin < lo_b) begin
          out_pix <= lo_b;
          flag_lo <= vld[LAYERS];
        end else if (c_fin > hi_b) begin
          out_pix <= hi_b;
          flag_hi <= vld[LAYERS];
        end
      end
    end
  end

  initial if (LAT != 8) $error("pipeline depth must stay 8");

endmodule

// File: rtl/bayer_dpc_clamp_chk.sv
module bayer_dpc_clamp_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [DW-1:0] centre,
  input logic          bypass,
  input logic          out_valid,
  input logic [DW-1:0] out_pix,
  input logic          flag_hi,
  input logic          flag_lo
);

  logic [3:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 4'd15) since_rst <= since_rst + 4'd1;
  end
  wire warm = since_rst >= 4'd8;

  p_flag_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_hi && flag_lo));

  p_flag_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_hi || flag_lo) |-> out_valid);

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 8)));

  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid && bypass, 8)) |-> (out_pix == $past(centre, 8) && !flag_hi && !flag_lo));

  p_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && flag_lo) |-> (out_pix > $past(centre, 8)));

  p_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && flag_hi) |-> (out_pix < $past(centre, 8)));

  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && !flag_hi && !flag_lo) |-> (out_pix == $past(centre, 8)));

endmodule

bind bayer_dpc_clamp bayer_dpc_clamp_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .centre(in_win[12*DW +: DW]), .bypass(bypass),
  .out_valid(out_valid), .out_pix(out_pix), .flag_hi(flag_hi), .flag_lo(flag_lo)
);

// File: tb/bayer_dpc_clamp_bench.sv
module bayer_dpc_clamp_bench;
  localparam int DW = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [25*DW-1:0] in_win = '0;
  logic [1:0]       cfa_phase = '0;
  logic             row_odd = 1'b0, col_odd = 1'b0;
  logic [1:0]       sens = '0;
  logic             bypass = 1'b0;
  logic             out_valid;
  logic [DW-1:0]    out_pix;
  logic             flag_hi, flag_lo;

  bayer_dpc_clamp #(.DW(DW)) u_bayer_dpc_clamp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_win(in_win),
    .cfa_phase(cfa_phase), .row_odd(row_odd), .col_odd(col_odd),
    .sens(sens), .bypass(bypass), .out_valid(out_valid), .out_pix(out_pix),
    .flag_hi(flag_hi), .flag_lo(flag_lo));

  always #10 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [DW-1:0] pix;
    logic          hi;
    logic          lo;
    int            due;
    string         tag;
  } exp_t;
  exp_t q[$];

  function automatic logic [DW-1:0] at(input logic [25*DW-1:0] w, input int r, input int c);
    return w[(r*5+c)*DW +: DW];
  endfunction

  function automatic exp_t model(input logic [25*DW-1:0] w, input logic [1:0] ph,
                                 input logic ro, input logic co, input logic [1:0] k,
                                 input logic b);
    exp_t e;
    logic [DW-1:0] s [8];
    logic [DW-1:0] t, c, lo, hi;
    logic [1:0] cls;
    cls = {ro ^ ph[1], co ^ ph[0]};
    s[4] = at(w,0,2); s[5] = at(w,2,0); s[6] = at(w,2,4); s[7] = at(w,4,2);
    if (cls == 2'b01 || cls == 2'b10) begin
      s[0] = at(w,1,1); s[1] = at(w,1,3); s[2] = at(w,3,1); s[3] = at(w,3,3);
    end else begin
      s[0] = at(w,0,0); s[1] = at(w,0,4); s[2] = at(w,4,0); s[3] = at(w,4,4);
    end
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 7 - i; j++)
        if (s[j] > s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
    c = at(w,2,2);
    lo = s[k];
    hi = s[7-k];
    e.pix = c; e.hi = 1'b0; e.lo = 1'b0; e.due = 0; e.tag = "";
    if (!b) begin
      if (c < lo) begin e.pix = lo; e.lo = 1'b1; end
      else if (c > hi) begin e.pix = hi; e.hi = 1'b1; end
    end
    return e;
  endfunction

  // v: corners 0..3, near diagonals 4..7, axial distance-two 8..11
  function automatic logic [25*DW-1:0] mk_win(input int v[12], input int rest, input int centre);
    logic [25*DW-1:0] w;
    for (int i = 0; i < 25; i++) w[i*DW +: DW] = DW'(rest);
    w[(0*5+0)*DW +: DW] = DW'(v[0]);  w[(0*5+4)*DW +: DW] = DW'(v[1]);
    w[(4*5+0)*DW +: DW] = DW'(v[2]);  w[(4*5+4)*DW +: DW] = DW'(v[3]);
    w[(1*5+1)*DW +: DW] = DW'(v[4]);  w[(1*5+3)*DW +: DW] = DW'(v[5]);
    w[(3*5+1)*DW +: DW] = DW'(v[6]);  w[(3*5+3)*DW +: DW] = DW'(v[7]);
    w[(0*5+2)*DW +: DW] = DW'(v[8]);  w[(2*5+0)*DW +: DW] = DW'(v[9]);
    w[(2*5+4)*DW +: DW] = DW'(v[10]); w[(4*5+2)*DW +: DW] = DW'(v[11]);
    w[(2*5+2)*DW +: DW] = DW'(centre);
    return w;
  endfunction

  task automatic fail(input string tag, input string what, input int act, input int expv);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
  endtask

  task automatic send(input logic [25*DW-1:0] w, input logic [1:0] ph, input logic ro,
                      input logic co, input logic [1:0] k, input logic b, input string tag);
    exp_t e;
    @(negedge clk);
    in_win = w; cfa_phase = ph; row_odd = ro; col_odd = co; sens = k; bypass = b;
    in_valid = 1'b1;
    e = model(w, ph, ro, co, k, b);
    e.due = cyc + 8;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_win = '1;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if ((flag_hi || flag_lo) && !out_valid) begin
        checks++; fail("R11", "flag without valid", 1, 0);
      end
      if (flag_hi && flag_lo) begin
        checks++; fail("R11", "both flags", 1, 0);
      end
      if (out_valid) begin
        checks++;
        if (q.size() == 0) fail("R10", "unexpected out_valid", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          if (cyc != e.due) fail("R9", "output cycle", cyc, e.due);
          else if (out_pix !== e.pix) fail(e.tag, "out_pix", int'(out_pix), int'(e.pix));
          else if (flag_hi !== e.hi) fail(e.tag, "flag_hi", int'(flag_hi), int'(e.hi));
          else if (flag_lo !== e.lo) fail(e.tag, "flag_lo", int'(flag_lo), int'(e.lo));
        end
      end else if (q.size() != 0 && q[0].due <= cyc) begin
        checks++;
        fail("R9", "missing out_valid", 0, 1);
        void'(q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 150000);
    checks++;
    fail("R9", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int v[12];
    logic [25*DW-1:0] w;
    void'($urandom(32'd4242));

    // R10: inputs presented during reset never emerge
    in_valid = 1'b1;
    in_win = '0;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || flag_hi !== 1'b0 || flag_lo !== 1'b0)
      fail("R10", "outputs in reset", int'({out_valid, flag_hi, flag_lo}), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    idle(12);

    // R1/R2/R3: corners=100, diagonals=500, axials=300, centre low
    for (int i = 0; i < 4; i++) begin v[i] = 100; v[i+4] = 500; v[i+8] = 300; end
    w = mk_win(v, 900, 0);
    send(w, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, "R2");
    send(w, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0, "R3");
    send(w, 2'd1, 1'b0, 1'b0, 2'd0, 1'b0, "R1");
    send(w, 2'd3, 1'b1, 1'b0, 2'd3, 1'b0, "R1");
    send(w, 2'd2, 1'b1, 1'b0, 2'd0, 1'b0, "R1");
    idle(10);

    // R4/R5/R6/R7: distinct ranks 10..80 in the non-green set
    for (int i = 0; i < 4; i++) begin v[i] = 10 * (i + 1); v[i+4] = 1000; v[i+8] = 10 * (i + 5); end
    for (int k = 0; k < 4; k++) begin
      send(mk_win(v, 1, 5),  2'd0, 1'b0, 1'b0, 2'(k), 1'b0, "R5");
      send(mk_win(v, 1, 90), 2'd0, 1'b0, 1'b0, 2'(k), 1'b0, "R6");
    end
    send(mk_win(v, 1, 45), 2'd0, 1'b0, 1'b0, 2'd3, 1'b0, "R7");
    send(mk_win(v, 1, 40), 2'd0, 1'b0, 1'b0, 2'd3, 1'b0, "R7");
    send(mk_win(v, 1, 50), 2'd0, 1'b0, 1'b0, 2'd3, 1'b0, "R4");
    send(mk_win(v, 1, 10), 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, "R4");
    send(mk_win(v, 1, 80), 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, "R4");
    idle(3);

    // R8: bypass with extreme centres
    send(mk_win(v, 1, 0),    2'd0, 1'b0, 1'b0, 2'd3, 1'b1, "R8");
    send(mk_win(v, 1, 1023), 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, "R8");
    idle(10);

    // R9 and all: random traffic with gaps and outliers
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 5 == 0) idle(1 + $urandom % 3);
      for (int i = 0; i < 25; i++) w[i*DW +: DW] = DW'($urandom);
      case ($urandom % 4)
        0: w[12*DW +: DW] = '0;
        1: w[12*DW +: DW] = '1;
        default: ;
      endcase
      send(w, 2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
           ($urandom % 8 == 0), "R9");
    end
    idle(12);

    checks++;
    if (q.size() != 0) fail("R9", "samples left unanswered", q.size(), 0);
    finish_run();
  end

endmodule